// File: doc/BRIEF.md
# Shift Register Test Cipher

This block is a deliberately transparent stand-in for a stream cipher. It is meant for calibrating a side-channel measurement rig. Its whole secret state is a 32-bit shift register. The register is filled serially from a seed input, and only in cycles where a load strobe is high.

On every strobed cycle the block does two things at once. It shifts the register by one place, taking the new seed bit in at the low end. It also produces one ciphertext bit: the bit about to leave the top stage, XORed with the plaintext bit that arrives in the same cycle. The ciphertext bit is registered, and a valid flag marks the cycle in which it appears.

Because the state is known exactly at every point, a rig can line up its power or EM traces against predictable switching activity. Straight after reset the register holds zeros, so plaintext passes through unchanged. This gives a simple end-to-end check of the serial path before any seed has reached the output tap.

Top module: `sreg_test_cipher`

## Requirements
- R1: While `rst` is high at a rising edge, the register is cleared to all zeros. At the same edge `cipherOut` goes to 0 and `cipherValid` goes to 0.
- R2: In a cycle with `shiftEn` low, `seedIn` and `plainIn` are ignored. The register and `cipherOut` keep their values.
- R3: In a cycle with `shiftEn` high, the register shifts one place toward the top. `seedIn` enters at bit 0.
- R4: In a cycle with `shiftEn` high, `cipherOut` takes the value of register bit 31 from before the shift, XORed with `plainIn`. The new value is visible after that rising edge.
- R5: `cipherValid` is high in exactly the cycle after each cycle with `shiftEn` high (and `rst` low), and low otherwise.
- R6: A seed bit taken in on a given shift becomes the output tap 32 shifts later. `cipherOut` on that later shift equals that seed bit XOR the plaintext bit of that shift.
- R7: While the register holds all zeros, `cipherOut` equals the `plainIn` of the shifting cycle. This covers the first 32 shifts after reset.
- R8: Reset takes priority over `shiftEn`. A seed bit presented during reset never enters the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seedIn | input | 1 | Serial seed bit shifted into bit 0 |
| shiftEn | input | 1 | Load strobe; shift and encrypt one bit this cycle |
| plainIn | input | 1 | Plaintext bit for the current shift |
| cipherOut | output | 1 | Registered ciphertext bit |
| cipherValid | output | 1 | High for one cycle after each strobed shift |

## Verification
`cipherOut` and `cipherValid` are each due one rising edge after the strobed cycle that produces them. The bench therefore drives every input on a falling edge and samples the outputs on the next falling edge, half a period after the edge that updated them. A seed bit becomes visible only 32 strobed shifts after it enters, and hold cycles do not count toward those 32. The directed tests therefore count shifts, not cycles, when they predict which seed bit reaches the tap. Hold cycles placed in the middle of a drain then show that the register did not move while `shiftEn` was low.

// File: rtl/sreg_cipher_pkg.sv
package sreg_cipher_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic clear;    // wipe register and output bit
    logic advance;  // shift one place and encrypt one bit
  } dp_strobe_t;

endpackage

// File: rtl/sreg_cipher_ctrl.sv
module sreg_cipher_ctrl
  import sreg_cipher_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       shiftEn,
  output dp_strobe_t strobes,
  output logic       cipherValid
);

  // Reset wins over the load strobe (R8)
  always_comb begin
    strobes.clear   = rst;
    strobes.advance = shiftEn & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) cipherValid <= 1'b0;
    else     cipherValid <= shiftEn;
  end

  // R5: valid follows each strobed cycle
  a_r5_valid_after_shift: assert property (@(posedge clk) disable iff (rst)
    shiftEn |=> cipherValid);

  // R5: no valid without a strobe
  a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !shiftEn |=> !cipherValid);

endmodule

// File: rtl/sreg_cipher_dp.sv
module sreg_cipher_dp
  import sreg_cipher_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  dp_strobe_t strobes,
  input  logic       seedIn,
  input  logic       plainIn,
  output logic       cipherOut
);

  localparam int TAP = WIDTH - 1;

  logic [WIDTH-1:0] stateReg;

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      stateReg  <= '0;
      cipherOut <= 1'b0;
    end else if (strobes.advance) begin
      stateReg  <= {stateReg[TAP-1:0], seedIn};
      cipherOut <= stateReg[TAP] ^ plainIn;
    end
  end

  // R3: one-place shift with the seed at bit 0
  a_r3_shift_in: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.advance |=> (stateReg[0] == $past(seedIn)) &&
                        (stateReg[TAP:1] == $past(stateReg[TAP-1:0])));

  // R4: output is the old top bit XOR plaintext
  a_r4_cipher_bit: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.advance |=> cipherOut == $past(stateReg[TAP] ^ plainIn));

  // R2: register holds without a strobe
  a_r2_hold_state: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.advance |=> $stable(stateReg));

  // R2: output bit holds without a strobe
  a_r2_hold_out: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.advance |=> $stable(cipherOut));

endmodule

// File: rtl/sreg_test_cipher.sv
module sreg_test_cipher
  import sreg_cipher_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic seedIn,
  input  logic shiftEn,
  input  logic plainIn,
  output logic cipherOut,
  output logic cipherValid
);

  dp_strobe_t strobes;

  sreg_cipher_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .shiftEn    (shiftEn),
    .strobes    (strobes),
    .cipherValid(cipherValid)
  );

  sreg_cipher_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .seedIn   (seedIn),
    .plainIn  (plainIn),
    .cipherOut(cipherOut)
  );

endmodule

// File: tb/sreg_test_cipher_bench.sv
module sreg_test_cipher_bench;

  logic clk = 1'b0;
  logic rst, seedIn, shiftEn, plainIn;
  logic cipherOut, cipherValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sreg_test_cipher u_sreg_test_cipher (
    .clk(clk), .rst(rst), .seedIn(seedIn), .shiftEn(shiftEn),
    .plainIn(plainIn), .cipherOut(cipherOut), .cipherValid(cipherValid)
  );

  // {en, seed, plain, expOut, expValid}, applied right after reset
  typedef struct packed {
    logic en; logic seed; logic plain; logic expOut; logic expValid;
  } vec_t;

  localparam vec_t VECS [12] = '{
    5'b11111, 5'b10001, 5'b01100, 5'b11001, 5'b10111, 5'b00010,
    5'b01010, 5'b11111, 5'b11001, 5'b10111, 5'b00110, 5'b10001
  };

  localparam logic [31:0] PATTERN = 32'hC3A5_1E96;

  task automatic check(input string req, input logic act, input logic exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, then sample at the next falling edge
  task automatic step(input logic r, input logic en, input logic s,
                      input logic p);
    rst = r; shiftEn = en; seedIn = s; plainIn = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; shiftEn = 1'b0; seedIn = 1'b0; plainIn = 1'b0;
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check("R1", cipherOut, 1'b0, "out after reset");
    check("R1", cipherValid, 1'b0, "valid after reset");

    // Vector table: zero register, so strobed outputs equal plaintext (R7)
    for (int i = 0; i < 12; i++) begin
      step(1'b0, VECS[i].en, VECS[i].seed, VECS[i].plain);
      check("R7/R2", cipherOut, VECS[i].expOut, $sformatf("vec %0d out", i));
      check("R5", cipherValid, VECS[i].expValid, $sformatf("vec %0d valid", i));
    end

    // Load a known pattern from a clean start; top bit enters first
    step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 1'b1, PATTERN[31-i], i[1]);
      check("R7", cipherOut, i[1], $sformatf("load %0d passthrough", i));
    end

    // Drain: shift j delivers the bit taken in on load shift j (R6, R3, R4)
    for (int j = 0; j < 32; j++) begin
      step(1'b0, 1'b1, 1'b0, j[0]);
      check("R6", cipherOut, PATTERN[31-j] ^ j[0], $sformatf("drain %0d", j));
      check("R5", cipherValid, 1'b1, $sformatf("drain %0d valid", j));
      if (j == 15) begin
        // R2: hold cycles with busy inputs leave output and state untouched
        for (int h = 0; h < 5; h++) begin
          step(1'b0, 1'b0, h[0], ~h[0]);
          check("R2", cipherOut, PATTERN[31-j] ^ j[0], $sformatf("hold %0d out", h));
          check("R5", cipherValid, 1'b0, $sformatf("hold %0d valid", h));
        end
      end
    end

    // R8: fill with ones, then reset while strobing with seed high
    for (int i = 0; i < 32; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    check("R8", cipherOut, 1'b0, "out under reset with strobe");
    check("R8", cipherValid, 1'b0, "valid under reset with strobe");
    for (int k = 0; k < 32; k++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0);
      check("R8", cipherOut, 1'b0, $sformatf("cleared state bit %0d", k));
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5", cipherValid, 1'b0, "idle after drain");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule